// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt pins and one non-maskable interrupt (NMI) pin and turns pin activity into latched request flags. Each pin goes through a two-flop synchroniser. Each of the eight lines has its own 2-bit trigger selection: low level, falling edge, rising edge or both edges. When the selected condition is seen, the line's pending flag is set. The flag drives a dedicated request output to a parent interrupt controller and stays set until software clears it.

Software reaches the block over a small 16-bit register bus. The bus has a byte address, a write enable, write data and combinational read data. Three registers are mapped:

- Byte offset 0 holds the NMI control: the live level, the edge selection and the request flag.
- Byte offset 2 holds the sense selection for all eight lines.
- Byte offset 4 holds the eight pending flags.

A flag is cleared by writing 0 to its bit. Writing 1 leaves a flag as it is, so one flag can be cleared without a read-modify-write of the others. Masking and priority belong to the parent controller and are not part of this block.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every sense field is 0 (low level), every line flag and the NMI flag are 0, and the NMI edge select is 0 (falling). The synchroniser flops reset to logic high.
- R2: The register at byte offset 2 is read/write. The sense code for line n is at bits 2n+1:2n, with 0 = low level, 1 = falling edge, 2 = rising edge and 3 = both edges.
- R3: With sense code 1, a high-to-low change on a line's pin sets that line's flag at the third rising clock edge after the pin changes. A low-to-high change does not set it.
- R4: With sense code 2, a low-to-high change sets the flag and a high-to-low change does not.
- R5: With sense code 3, both a falling change and a rising change set the flag.
- R6: With sense code 0, the flag is set and held while the synchronised pin is low. Writing 0 to the flag has no effect while the pin stays low. The flag stays set after the pin returns high, until it is cleared.
- R7: The register at byte offset 4 holds line n's flag at bit n (bits 7:0). Writing 0 to a bit clears that flag. Writing 1 to a bit leaves that flag unchanged.
- R8: When a sense event and a clearing write to the same flag fall in the same cycle, the flag ends up set.
- R9: At byte offset 0, bit 15 reads the synchronised NMI pin level. Bit 8 is a read/write edge select: 0 = falling, 1 = rising. Bit 1 is the NMI flag. It is set on the selected edge only and cleared by writing 0 to bit 1.
- R10: Unused bits of the mapped registers read 0. Addresses other than 0, 2 and 4 read 0, and writes to them change no register.
- R11: Output irq_req[n] equals line n's flag, and output nmi_req equals the NMI flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 8 | Asynchronous external interrupt pins |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| addr | input | 3 | Register byte address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data, combinational |
| irq_req | output | 8 | Per-line request to parent controller |
| nmi_req | output | 1 | NMI request to parent controller |

## Verification
Each of the eight lines is swept through all four sense codes under the same stimulus:

1. The pin is driven low.
2. A clearing write is issued while the pin is still low.
3. The pin is released high.
4. A second clearing write is issued.

After each step the whole flag register is compared against the expected value, which is what separates the codes. Level mode is the only code that survives the first clear. Falling and both-edges set the flag on the low step, and rising and both-edges set it on the high step. The sweep also confirms that no other line's flag moves.

Separate sequences cover four further cases:

- Clearing one flag by writing ones to the rest.
- A clear that lands in exactly the cycle of a set.
- The NMI pin under both edge selections, including the edge that must not set the flag.
- Writes and reads at unmapped addresses.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int NUM_LINES  = 8;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 3;
    localparam int SYNC_DEPTH = 2;

    localparam logic [ADDR_W-1:0] OFS_NMI   = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_SENSE = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_FLAG  = 3'd4;

    localparam int NMI_LVL_BIT  = 15;
    localparam int NMI_EDGE_BIT = 8;
    localparam int NMI_FLAG_BIT = 1;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_BOTH = 2'd3
    } sense_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic low;
    } pin_cond_t;

    function automatic pin_cond_t classify(logic now_lvl, logic prev_lvl);
        pin_cond_t c;
        c.rise = now_lvl & ~prev_lvl;
        c.fall = ~now_lvl & prev_lvl;
        c.low  = ~now_lvl;
        return c;
    endfunction

    function automatic logic sense_hit(sense_e mode, pin_cond_t c);
        case (mode)
            SENSE_LOW:  return c.low;
            SENSE_FALL: return c.fall;
            SENSE_RISE: return c.rise;
            default:    return c.rise | c.fall;
        endcase
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '1;
                else     chain_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '1;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/extint_line.sv
module extint_line
    import extint_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   level,
    input  sense_e mode,
    input  logic   clr,
    output logic   flag
);
    logic      prev_q;
    logic      flag_q;
    logic      hit;
    pin_cond_t cond;

    always_comb begin
        cond = classify(level, prev_q);
        hit  = sense_hit(mode, cond);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            prev_q <= level;
            flag_q <= hit | (flag_q & ~clr);
        end
    end

    assign flag = flag_q;

    // R8: an event always leaves the flag set, even with a clear pending
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_FALL && prev_q && !level) |=> flag_q);
    // R4: rising change in rising mode sets the flag
    a_r4_rise_sets: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_RISE && !prev_q && level) |=> flag_q);
    // R6: low level holds the flag
    a_r6_level_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_LOW && !level) |=> flag_q);
    // R7: a flag only drops through a clearing write
    a_r7_clear_only: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(clr));
endmodule

// File: rtl/extint_nmi.sv
module extint_nmi (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic rise_sel,
    input  logic clr,
    output logic flag
);
    logic prev_q;
    logic flag_q;
    logic edge_hit;

    always_comb begin
        if (rise_sel) edge_hit = level & ~prev_q;
        else          edge_hit = ~level & prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            prev_q <= level;
            flag_q <= edge_hit | (flag_q & ~clr);
        end
    end

    assign flag = flag_q;

    // R9: the flag rises only on a change of the synchronised level
    a_r9_nmi_on_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(level != prev_q));
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int LINES = NUM_LINES,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int SYNC  = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] irq_pin,
    input  logic             nmi_pin,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic [LINES-1:0] irq_req,
    output logic             nmi_req
);
    localparam int SENSE_W = 2 * LINES;
    localparam int PINS    = LINES + 1;

    logic [PINS-1:0]    pins_s;
    logic [SENSE_W-1:0] sense_q;
    logic               nmi_rise_q;
    logic [LINES-1:0]   flags;
    logic               nmi_flag;
    logic               wr_nmi, wr_sense, wr_flag;

    extint_sync #(.WIDTH(PINS), .STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({nmi_pin, irq_pin}),
        .dout (pins_s)
    );

    assign wr_nmi   = wr_en && (addr == OFS_NMI);
    assign wr_sense = wr_en && (addr == OFS_SENSE);
    assign wr_flag  = wr_en && (addr == OFS_FLAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q    <= '0;
            nmi_rise_q <= 1'b0;
        end else begin
            if (wr_sense) sense_q    <= wdata[SENSE_W-1:0];
            if (wr_nmi)   nmi_rise_q <= wdata[NMI_EDGE_BIT];
        end
    end

    for (genvar n = 0; n < LINES; n++) begin : g_line
        extint_line u_line (
            .clk   (clk),
            .rst   (rst),
            .level (pins_s[n]),
            .mode  (sense_e'(sense_q[2*n +: 2])),
            .clr   (wr_flag && !wdata[n]),
            .flag  (flags[n])
        );
    end

    extint_nmi u_nmi (
        .clk      (clk),
        .rst      (rst),
        .level    (pins_s[LINES]),
        .rise_sel (nmi_rise_q),
        .clr      (wr_nmi && !wdata[NMI_FLAG_BIT]),
        .flag     (nmi_flag)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_NMI: begin
                rdata[NMI_LVL_BIT]  = pins_s[LINES];
                rdata[NMI_EDGE_BIT] = nmi_rise_q;
                rdata[NMI_FLAG_BIT] = nmi_flag;
            end
            OFS_SENSE: rdata[SENSE_W-1:0] = sense_q;
            OFS_FLAG:  rdata[LINES-1:0]   = flags;
            default:   rdata = '0;
        endcase
    end

    assign irq_req = flags;
    assign nmi_req = nmi_flag;

    // R2 / R10: the sense register moves only on a write to its own offset
    a_r2_sense_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_sense |=> $stable(sense_q));
    // R9: the edge select moves only on a write to the NMI offset
    a_r9_edge_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_nmi |=> $stable(nmi_rise_q));
endmodule

// File: tb/sim_extint_ctrl.sv
`timescale 1ns/1ps
module sim_extint_ctrl;
    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  irq_pin = 8'hFF;
    logic        nmi_pin = 1'b1;
    logic [2:0]  addr = '0;
    logic        wr_en = 0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:0]  irq_req;
    logic        nmi_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    extint_ctrl u0 (
        .clk(clk), .rst(rst), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
        .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .irq_req(irq_req), .nmi_req(nmi_req)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  e;
        repeat (4) @(negedge clk);
        rst = 0;
        settle();

        // R1: reset state
        bus_rd(3'd0, v); chk("R1 nmi ctrl", v, 16'h8000);
        bus_rd(3'd2, v); chk("R1 sense", v, 16'h0000);
        bus_rd(3'd4, v); chk("R1 flags", v, 16'h0000);
        chk("R1 R11 outputs", {7'b0, nmi_req, irq_req}, 16'h0000);

        // R2: sense register read-back
        bus_wr(3'd2, 16'hA5C3); bus_rd(3'd2, v); chk("R2 sense rw", v, 16'hA5C3);

        // R3 R4 R5 R6 R7: sweep every line through every mode
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 4; m++) begin
                bus_wr(3'd2, 16'(m) << (2*n));
                bus_wr(3'd4, 16'h0000);
                bus_rd(3'd4, v); chk("R7 pre-clear", v, 16'h0000);
                irq_pin[n] = 1'b0; settle();
                e = (m != 2) ? (8'd1 << n) : 8'd0;
                bus_rd(3'd4, v); chk("R3 R4 R5 R6 fall step", v, {8'h00, e});
                chk("R11 irq_req fall", {8'h00, irq_req}, {8'h00, e});
                bus_wr(3'd4, 16'h0000);
                e = (m == 0) ? (8'd1 << n) : 8'd0;
                bus_rd(3'd4, v); chk("R6 clear while low", v, {8'h00, e});
                irq_pin[n] = 1'b1; settle();
                if (m >= 2) e = 8'd1 << n;
                bus_rd(3'd4, v); chk("R3 R4 R5 R6 rise step", v, {8'h00, e});
                bus_wr(3'd4, 16'h0000);
                bus_rd(3'd4, v); chk("R6 R7 final clear", v, 16'h0000);
            end
        end

        // R7: writing ones keeps other flags
        bus_wr(3'd2, 16'h5555);
        irq_pin = 8'b1101_1011; settle();
        irq_pin = 8'hFF; settle();
        bus_rd(3'd4, v); chk("R7 two set", v, 16'h0024);
        bus_wr(3'd4, 16'hFFFB);
        bus_rd(3'd4, v); chk("R7 keep ones", v, 16'h0020);
        bus_wr(3'd4, 16'h0000);

        // R8: clear write in the same cycle as the set
        @(negedge clk); irq_pin[0] = 1'b0;
        @(negedge clk);
        @(negedge clk); addr = 3'd4; wdata = 16'h0000; wr_en = 1;
        @(negedge clk); wr_en = 0;
        chk("R8 set wins", {15'b0, irq_req[0]}, 16'h0001);
        irq_pin[0] = 1'b1; settle();
        bus_wr(3'd4, 16'h0000);

        // R9: NMI with falling select
        nmi_pin = 1'b0; settle();
        bus_rd(3'd0, v); chk("R9 nmi falling", v, 16'h0002);
        chk("R11 nmi_req", {15'b0, nmi_req}, 16'h0001);
        bus_wr(3'd0, 16'h0000);
        nmi_pin = 1'b1; settle();
        bus_rd(3'd0, v); chk("R9 nmi rise ignored", v, 16'h8000);
        // R9: NMI with rising select
        bus_wr(3'd0, 16'h0100);
        nmi_pin = 1'b0; settle();
        bus_rd(3'd0, v); chk("R9 nmi fall ignored", v, 16'h0100);
        nmi_pin = 1'b1; settle();
        bus_rd(3'd0, v); chk("R9 nmi rising", v, 16'h8102);
        bus_wr(3'd0, 16'h0102);
        bus_rd(3'd0, v); chk("R9 nmi write one keeps", v, 16'h8102);
        bus_wr(3'd0, 16'h0100);
        bus_rd(3'd0, v); chk("R9 nmi clear", v, 16'h8100);

        // R10: unmapped addresses and unused bits
        bus_wr(3'd2, 16'h0000);
        for (int a = 0; a < 8; a++) begin
            if (a == 0 || a == 2 || a == 4) continue;
            bus_wr(3'(a), 16'hFFFF);
            bus_rd(3'(a), v); chk("R10 unmapped read", v, 16'h0000);
        end
        bus_rd(3'd2, v); chk("R10 sense untouched", v, 16'h0000);
        bus_rd(3'd0, v); chk("R10 nmi untouched", v, 16'h8100);
        bus_wr(3'd0, 16'hFFFF);
        bus_rd(3'd0, v); chk("R10 nmi unused bits", v, 16'h8100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule